// File: doc/BRIEF.md
# Timestamped Output Event Scheduler

This block turns timed commands from a processor into exact edges on one digital output pin. Each command carries a target time and the level the pin should take. Accepted commands wait in a small queue. The head of the queue is released onto the pin when a free-running wall-clock counter reaches its time. Because of this, edge placement depends only on the counter and not on when the processor gets around to writing.

A command whose time is already behind the counter when it is offered is discarded, and a sticky late-submission flag is raised. The flag stays set until it is cleared explicitly. A pulse is written as two commands: one for the rising edge and one for the falling edge.

A parameter picks the pin variant. The bidirectional variant starts out not driving and drives only after a mode command. The output-only variant always drives.

Top module: `timed_output_scheduler`

## Requirements
- R1: `now_o` is 0 in the cycle after reset is released, and it increases by exactly 1 on every clock as an unsigned `TS_W`-bit count.
- R2: A command accepted with a time T of at least `now_o`+1 puts its level on `pin_o` starting in the cycle where `now_o` equals T+1. If T equals `now_o` at acceptance, the level appears in the cycle where `now_o` equals T+2.
- R3: A command accepted while its time is smaller than `now_o` (unsigned compare) is dropped, and `pin_o` never takes its level. `underflow` reads 1 in the next cycle.
- R4: `underflow` stays at 1 until `uf_clr` is high on a clock edge and then reads 0 afterwards. If `uf_clr` and a late command fall on the same edge, the flag stays at 1.
- R5: Queued commands are released in the order they were submitted, at most one per clock. A train of pulses, each 2 counts high and repeating every 4 counts, holds `pin_o` high for exactly 2 of every 4 cycles.
- R6: The queue holds `DEPTH` commands. `wr_ready` is 0 while `DEPTH` commands are pending, and `wr_valid` has no effect while `wr_ready` is 0.
- R7: With `BIDIR`=1, `pin_oe` is 0 until a clock edge where `mode_wr`=1 and `mode_out`=1. After that it is 1. A later `mode_wr` with `mode_out`=0 sets it back to 0. With `BIDIR`=0, `pin_oe` is always 1.
- R8: Reset empties the queue, clears `underflow`, drives `pin_o` to 0 and returns the bidirectional variant to not driving. Commands that were pending before reset never reach the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the wall clock advances once per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A command is offered |
| wr_ready | output | 1 | The queue can take a command |
| wr_time | input | TS_W | Target time of the offered command |
| wr_level | input | 1 | Pin level of the offered command |
| mode_wr | input | 1 | Load the pin direction from `mode_out` |
| mode_out | input | 1 | 1 = drive the pin, 0 = release it |
| uf_clr | input | 1 | Clear the late-submission flag |
| underflow | output | 1 | Sticky late-submission flag |
| now_o | output | TS_W | Current wall-clock count |
| pin_o | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin drive enable |

## Verification
Two of this block's functions can act on the same edge: clearing the sticky flag and detecting a new late command. The bench first sets the flag with a late command. It then offers a second late command in the same cycle as it raises `uf_clr`, and expects `underflow` to still read 1 one cycle later. Only a separate clear afterwards may bring the flag down. The bench also releases queued events while new ones are being written, and compares the pin against the time of each edge computed from the counter at submission.

// File: rtl/tos_pkg.sv
package tos_pkg;

   typedef enum logic {
      PIN_RELEASED = 1'b0,
      PIN_DRIVEN   = 1'b1
   } pin_dir_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tos_wallclock.sv
module tos_wallclock #(
   parameter int unsigned CW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] count
);

   if (CW < 2) begin : g_bad_width
      $error("tos_wallclock: CW must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/tos_event_fifo.sv
module tos_event_fifo #(
   parameter int unsigned W     = 65,
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   import tos_pkg::*;

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("tos_event_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/tos_pin_driver.sv
module tos_pin_driver #(
   parameter bit BIDIR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic level,
   input  logic mode_wr,
   input  logic mode_out,
   output logic pin_o,
   output logic pin_oe
);
   import tos_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_o <= 1'b0;
      end else if (load) begin
         pin_o <= level;
      end
   end

   if (BIDIR) begin : g_bidir
      pin_dir_e dir_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_q <= PIN_RELEASED;
         end else if (mode_wr) begin
            dir_q <= mode_out ? PIN_DRIVEN : PIN_RELEASED;
         end
      end

      assign pin_oe = (dir_q == PIN_DRIVEN);
   end else begin : g_out_only
      logic unused_mode;
      assign unused_mode = mode_wr ^ mode_out;
      assign pin_oe      = 1'b1;
   end

endmodule

// File: rtl/timed_output_scheduler.sv
module timed_output_scheduler #(
   parameter int unsigned TS_W  = 64,
   parameter int unsigned DEPTH = 16,
   parameter bit          BIDIR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_valid,
   output logic            wr_ready,
   input  logic [TS_W-1:0] wr_time,
   input  logic            wr_level,
   input  logic            mode_wr,
   input  logic            mode_out,
   input  logic            uf_clr,
   output logic            underflow,
   output logic [TS_W-1:0] now_o,
   output logic            pin_o,
   output logic            pin_oe
);

   localparam int unsigned PW = TS_W + 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (TS_W < 2) begin : g_bad_ts
      $error("timed_output_scheduler: TS_W must be at least 2");
   end

   logic [CW-1:0]   fifo_cnt;
   logic            fifo_full;
   logic            fifo_empty;
   logic [PW-1:0]   head_evt;
   logic [TS_W-1:0] head_ts;
   logic            head_lvl;
   logic            wr_fire;
   logic            late_wr;
   logic            push_evt;
   logic            pop_evt;

   tos_wallclock #(
      .CW (TS_W)
   ) u_clock (
      .clk   (clk),
      .rst_n (rst_n),
      .count (now_o)
   );

   assign wr_ready = !fifo_full;
   assign wr_fire  = wr_valid && wr_ready;
   assign late_wr  = wr_fire && (wr_time < now_o);
   assign push_evt = wr_fire && !late_wr;

   assign head_ts  = head_evt[PW-1:1];
   assign head_lvl = head_evt[0];
   assign pop_evt  = !fifo_empty && (head_ts <= now_o);

   tos_event_fifo #(
      .W     (PW),
      .DEPTH (DEPTH)
   ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_evt),
      .din   ({wr_time, wr_level}),
      .pop   (pop_evt),
      .dout  (head_evt),
      .count (fifo_cnt),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         underflow <= 1'b0;
      end else if (late_wr) begin
         underflow <= 1'b1;
      end else if (uf_clr) begin
         underflow <= 1'b0;
      end
   end

   tos_pin_driver #(
      .BIDIR (BIDIR)
   ) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pop_evt),
      .level    (head_lvl),
      .mode_wr  (mode_wr),
      .mode_out (mode_out),
      .pin_o    (pin_o),
      .pin_oe   (pin_oe)
   );

endmodule

// File: rtl/tos_checker.sv
module tos_checker #(
   parameter int unsigned TS_W  = 64,
   parameter int unsigned DEPTH = 16,
   parameter bit          BIDIR = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_valid,
   input logic                       wr_ready,
   input logic [TS_W-1:0]            wr_time,
   input logic                       mode_wr,
   input logic                       mode_out,
   input logic                       uf_clr,
   input logic                       underflow,
   input logic [TS_W-1:0]            now_o,
   input logic                       pin_o,
   input logic                       pin_oe,
   input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
   input logic                       pop_evt
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic past_ok;
   logic late_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
      end
   end

   assign late_seen = wr_valid && wr_ready && (wr_time < now_o);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (now_o == $past(now_o) + 1'b1)); // R1

   AST_PIN_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$stable(pin_o)) |-> $past(pop_evt)); // R2

   AST_LATE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      late_seen |=> underflow); // R3

   AST_LATE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      late_seen |=> (fifo_cnt <= $past(fifo_cnt))); // R3

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !uf_clr) |=> underflow); // R4

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_clr && !late_seen) |=> !underflow); // R4

   AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cnt == CW'(DEPTH)) |-> !wr_ready); // R6

   if (BIDIR) begin : g_bidir_chk
      AST_OE_BY_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $rose(pin_oe)) |-> $past(mode_wr && mode_out)); // R7
   end

endmodule

bind timed_output_scheduler tos_checker #(
   .TS_W  (TS_W),
   .DEPTH (DEPTH),
   .BIDIR (BIDIR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .wr_time   (wr_time),
   .mode_wr   (mode_wr),
   .mode_out  (mode_out),
   .uf_clr    (uf_clr),
   .underflow (underflow),
   .now_o     (now_o),
   .pin_o     (pin_o),
   .pin_oe    (pin_oe),
   .fifo_cnt  (fifo_cnt),
   .pop_evt   (pop_evt)
);

// File: tb/timed_output_scheduler_tb.sv
module timed_output_scheduler_tb;

   localparam int unsigned TS_W   = 64;
   localparam int unsigned DEPTH  = 16;
   localparam time         CLK_PER = 10;
   localparam int          NV     = 6;

   localparam logic signed [15:0] V_OFF [NV] = '{16'sd5, -16'sd3, 16'sd1, 16'sd0, 16'sd12, -16'sd1};
   localparam logic               V_LVL [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_valid = 1'b0;
   logic            wr_ready;
   logic [TS_W-1:0] wr_time = '0;
   logic            wr_level = 1'b0;
   logic            mode_wr = 1'b0;
   logic            mode_out = 1'b0;
   logic            uf_clr = 1'b0;
   logic            underflow;
   logic [TS_W-1:0] now_o;
   logic            pin_o;
   logic            pin_oe;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PER / 2) clk = ~clk;

   timed_output_scheduler #(
      .TS_W  (TS_W),
      .DEPTH (DEPTH),
      .BIDIR (1'b1)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_time   (wr_time),
      .wr_level  (wr_level),
      .mode_wr   (mode_wr),
      .mode_out  (mode_out),
      .uf_clr    (uf_clr),
      .underflow (underflow),
      .now_o     (now_o),
      .pin_o     (pin_o),
      .pin_oe    (pin_oe)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_now(input logic [63:0] t);
      while (now_o != t) @(negedge clk);
   endtask

   task automatic submit(input logic [63:0] ts, input logic lvl);
      wr_valid = 1'b1;
      wr_time  = ts;
      wr_level = lvl;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PER * 100000);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] n;
      logic [63:0] ts;
      logic [63:0] base;
      logic        prev;
      int          highs;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      check("R8 ready after reset", wr_ready, 1);
      check("R8 flag after reset", underflow, 0);
      check("R8 pin after reset", pin_o, 0);
      check("R7 released after reset", pin_oe, 0);
      check("R1 count after reset", now_o, 1);
      n = now_o;
      @(negedge clk);
      check("R1 count step", now_o, n + 1);

      // Switch to driving
      mode_wr = 1'b1; mode_out = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
      check("R7 driven after mode command", pin_oe, 1);

      // Table of offsets and levels
      prev = 1'b0;
      for (int i = 0; i < NV; i++) begin
         n  = now_o;
         ts = n + 64'(longint'(V_OFF[i]));
         submit(ts, V_LVL[i]);
         if (V_OFF[i] < 0) begin
            check("R3 late flag", underflow, 1);
            repeat (3) @(negedge clk);
            check("R3 late level dropped", pin_o, prev);
            uf_clr = 1'b1;
            @(negedge clk);
            uf_clr = 1'b0;
            check("R4 flag cleared", underflow, 0);
         end else begin
            logic [63:0] vis;
            vis = (V_OFF[i] >= 1) ? ts + 1 : ts + 2;
            wait_now(vis - 1);
            check("R2 level held before edge", pin_o, prev);
            @(negedge clk);
            check("R2 level at edge", pin_o, V_LVL[i]);
            prev = V_LVL[i];
            check("R3 no flag on timely write", underflow, 0);
         end
         repeat (2) @(negedge clk);
      end

      // Pulse train: 2 high, period 4
      base = now_o + 20;
      for (int i = 0; i < 8; i++) begin
         submit(base + 64'(2 * i), ~i[0]);
      end
      highs = 0;
      for (int c = 1; c <= 16; c++) begin
         wait_now(base + 64'(c));
         check("R5 pulse level", pin_o, (((c - 1) % 4) < 2) ? 1 : 0);
         if (pin_o) highs++;
      end
      check("R5 duty high count", 64'(highs), 8);

      // Fill the queue
      base = now_o + 100;
      for (int i = 0; i < DEPTH; i++) begin
         submit(base + 64'(i), (i == DEPTH - 1) ? 1'b0 : 1'b1);
      end
      check("R6 ready low when full", wr_ready, 0);
      wr_valid = 1'b1; wr_time = base + 20; wr_level = 1'b1;
      repeat (3) @(negedge clk);
      wr_valid = 1'b0;
      check("R6 still full", wr_ready, 0);
      wait_now(base + 30);
      check("R6 write while full ignored", pin_o, 0);
      check("R6 ready after drain", wr_ready, 1);

      // Flag sticky and collision with clear
      submit(now_o - 5, 1'b1);
      repeat (3) @(negedge clk);
      check("R4 flag sticky", underflow, 1);
      uf_clr = 1'b1;
      wr_valid = 1'b1; wr_time = now_o - 2; wr_level = 1'b1;
      @(negedge clk);
      uf_clr = 1'b0; wr_valid = 1'b0;
      check("R4 late wins over clear", underflow, 1);
      uf_clr = 1'b1;
      @(negedge clk);
      uf_clr = 1'b0;
      check("R4 clear alone", underflow, 0);
      check("R3 late levels never shown", pin_o, 0);

      // Return to released
      mode_wr = 1'b1; mode_out = 1'b0;
      @(negedge clk);
      mode_wr = 1'b0;
      check("R7 released by mode command", pin_oe, 0);

      // Reset with pending work
      mode_wr = 1'b1; mode_out = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
      ts = now_o + 10;
      submit(ts, 1'b1);
      submit(now_o - 1, 1'b1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 flag cleared by reset", underflow, 0);
      check("R8 released by reset", pin_oe, 0);
      check("R8 pin low after reset", pin_o, 0);
      check("R1 count restarts", now_o, 1);
      wait_now(ts + 5);
      check("R8 pending event discarded", pin_o, 0);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule